// File: doc/BRIEF.md
# Trigger-Number Handshake Port

This block is the sending end of a level handshake with one device under test (DUT). When it accepts a trigger request, it stores a 16-bit trigger number and raises a single trigger line. The DUT answers by asserting busy. The port then lowers the line. After that, the DUT drives a slow clock of its own, and the port shifts the stored number out on the same trigger line, least significant bit first, one bit per DUT clock period.

When all bits are sent, the port keeps the line low until the DUT drops busy. Only then does it report itself ready again. A software-set ignore-busy control replaces the busy handshake with a fixed-length trigger pulse. An enable control masks the port completely. A veto-select control lets a high DUT clock block new triggers.

Busy and the DUT clock arrive from another clock domain. Each passes through a two-stage synchroniser before any logic uses it. The DUT clock is handled only through edge detection, so its period may be anything well above the synchroniser latency.

Top module: `trigHandshakePort`

## Requirements
- R1: After reset the trigger line is low, and `ready` is high when `portEnable` is 1, `dutBusy` and `dutClk` are low.
- R2: A request (`trigReq` high) in a cycle where `ready` is high is accepted, and the trigger line is high in the next cycle.
- R3: With `portEnable` at 0, `ready` is low and the trigger line never rises, whatever `trigReq` does.
- R4: With `ignoreBusy` at 0, a high `dutBusy` (after synchronisation) holds `ready` low and blocks requests; with `ignoreBusy` at 1 busy has no effect on `ready`.
- R5: With `clkVetoEn` at 1, a high `dutClk` holds `ready` low; with `clkVetoEn` at 0 the DUT clock does not affect `ready`.
- R6: With `ignoreBusy` at 0, the trigger line falls in the third system clock cycle after `dutBusy` rises (two synchroniser stages plus one state register).
- R7: With `ignoreBusy` at 1, the trigger line is a pulse exactly `PULSE_LEN` (default 4) cycles long.
- R8: The line then stays low for `GAP_LEN` (default 4) cycles. After that it carries bit 0 of the stored number, and each synchronised falling edge of `dutClk` advances it to the next bit (bit 1, then bit 2, up to bit 15). A receiver that samples just after each of 16 rising edges recovers the number exactly.
- R9: The number is captured only at acceptance. Changes to `trigNum` and further `trigReq` pulses during a transfer do not alter the bits sent or start a new trigger.
- R10: After the 16th falling edge the line is low. With `ignoreBusy` at 0, `ready` stays low until busy drops, and then rises three cycles later or sooner.
- R11: Whenever `ready` is high, the trigger line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trigReq | input | 1 | Trigger request, system clock domain |
| trigNum | input | 16 | Trigger number captured on acceptance |
| portEnable | input | 1 | Port enable; 0 masks the port |
| ignoreBusy | input | 1 | 1: use fixed pulse, do not wait on busy |
| clkVetoEn | input | 1 | 1: high DUT clock vetoes new triggers |
| dutBusy | input | 1 | Busy from DUT, asynchronous |
| dutClk | input | 1 | Serial clock from DUT, asynchronous |
| trigOut | output | 1 | Trigger and serial data line to DUT |
| ready | output | 1 | Port idle and not vetoed |

## Verification
The serial path is driven by a behavioural DUT whose clock runs 24 system cycles per period. It is tried with walking-one and walking-zero numbers, all-zero, all-one and mixed patterns, in both busy and ignore-busy modes. Walking ones and zeros separate a bit-order error from a stuck or shifted bit. All-zero shows that the trigger pulse is not mistaken for data. Ignore-busy transfers confirm that the pulse length comes from the counter and not from busy. Each veto source (mask, busy, DUT clock) is applied on its own against an otherwise ready port.

// File: rtl/trigHsPkg.sv
package trigHsPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HAND,
    ST_GAP,
    ST_SHIFT,
    ST_DRAIN
  } hsState_t;

  typedef struct packed {
    logic load;      // capture the trigger number
    logic shift;     // advance to next serial bit
    logic lineHigh;  // force line high (trigger phase)
    logic lineData;  // line carries current serial bit
  } hsStrobe_t;
endpackage

// File: rtl/trigHsSync.sv
module trigHsSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= asyncIn;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/trigHsCtrl.sv
module trigHsCtrl
  import trigHsPkg::*;
#(
  parameter int NUM_W     = 16,
  parameter int PULSE_LEN = 4,
  parameter int GAP_LEN   = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      trigReq,
  input  logic      portEnable,
  input  logic      ignoreBusy,
  input  logic      clkVetoEn,
  input  logic      busyS,
  input  logic      clkS,
  output hsStrobe_t str,
  output logic      ready
);
  localparam int TMR_MAX = (PULSE_LEN > GAP_LEN) ? PULSE_LEN : GAP_LEN;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BIT_W   = $clog2(NUM_W + 1);

  hsState_t         state;
  logic [TMR_W-1:0] timer;
  logic [BIT_W-1:0] bitCnt;
  logic             clkPrev;
  logic             clkFall;
  logic             accept;

  assign clkFall = clkPrev & ~clkS;
  assign ready   = (state == ST_IDLE) & portEnable & (ignoreBusy | ~busyS)
                 & ~(clkVetoEn & clkS);
  assign accept  = trigReq & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      timer   <= '0;
      bitCnt  <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkPrev <= clkS;
      unique case (state)
        ST_IDLE: begin
          timer  <= '0;
          bitCnt <= '0;
          if (accept) state <= ST_HAND;
        end
        ST_HAND: begin
          if ((!ignoreBusy && busyS) ||
              (ignoreBusy && timer == TMR_W'(PULSE_LEN - 1))) begin
            state <= ST_GAP;
            timer <= '0;
          end else if (timer < TMR_W'(PULSE_LEN - 1)) begin
            timer <= timer + 1'b1;
          end
        end
        ST_GAP: begin
          if (timer == TMR_W'(GAP_LEN - 1)) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (clkFall) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == BIT_W'(NUM_W - 1)) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (ignoreBusy || !busyS) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    str          = '0;
    str.load     = accept;
    str.shift    = (state == ST_SHIFT) & clkFall;
    str.lineHigh = (state == ST_HAND);
    str.lineData = (state == ST_SHIFT);
  end

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HAND && busyS && !ignoreBusy) |=> (state == ST_GAP));

  // R7
  pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HAND) |-> (timer < TMR_W'(PULSE_LEN)));

  // R8
  shift_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |=> (state == ST_SHIFT || state == ST_DRAIN));

  // R8
  bit_count_chk: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= BIT_W'(NUM_W));
endmodule

// File: rtl/trigHsData.sv
module trigHsData
  import trigHsPkg::*;
#(
  parameter int NUM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  hsStrobe_t        str,
  input  logic [NUM_W-1:0] trigNum,
  output logic             trigOut
);
  logic [NUM_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (rst) shReg <= '0;
    else if (str.load) shReg <= trigNum;
    else if (str.shift) shReg <= {1'b0, shReg[NUM_W-1:1]};
  end

  assign trigOut = str.lineHigh | (str.lineData & shReg[0]);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!str.load && !str.shift) |=> $stable(shReg));
endmodule

// File: rtl/trigHandshakePort.sv
module trigHandshakePort
  import trigHsPkg::*;
#(
  parameter int NUM_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 4,
  parameter int GAP_LEN     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigReq,
  input  logic [NUM_W-1:0] trigNum,
  input  logic             portEnable,
  input  logic             ignoreBusy,
  input  logic             clkVetoEn,
  input  logic             dutBusy,
  input  logic             dutClk,
  output logic             trigOut,
  output logic             ready
);
  logic [1:0] syncVec;
  hsStrobe_t  str;

  trigHsSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst(rst),
    .asyncIn({dutClk, dutBusy}),
    .syncOut(syncVec)
  );

  trigHsCtrl #(.NUM_W(NUM_W), .PULSE_LEN(PULSE_LEN), .GAP_LEN(GAP_LEN)) uCtrl (
    .clk(clk), .rst(rst), .trigReq(trigReq), .portEnable(portEnable),
    .ignoreBusy(ignoreBusy), .clkVetoEn(clkVetoEn),
    .busyS(syncVec[0]), .clkS(syncVec[1]),
    .str(str), .ready(ready)
  );

  trigHsData #(.NUM_W(NUM_W)) uData (
    .clk(clk), .rst(rst), .str(str), .trigNum(trigNum), .trigOut(trigOut)
  );

  // R2
  accept_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (trigReq && ready) |=> trigOut);

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> !trigOut);

  // R3
  mask_chk: assert property (@(posedge clk) disable iff (rst)
    !portEnable |-> !ready);
endmodule

// File: tb/trigHandshakePort_test.sv
module trigHandshakePort_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trigReq = 1'b0;
  logic [15:0] trigNum = '0;
  logic        portEnable = 1'b1;
  logic        ignoreBusy = 1'b0;
  logic        clkVetoEn = 1'b0;
  logic        dutBusy = 1'b0;
  logic        dutClk = 1'b0;
  logic        trigOut, ready;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  trigHandshakePort uut (
    .clk(clk), .rst(rst), .trigReq(trigReq), .trigNum(trigNum),
    .portEnable(portEnable), .ignoreBusy(ignoreBusy), .clkVetoEn(clkVetoEn),
    .dutBusy(dutBusy), .dutClk(dutClk), .trigOut(trigOut), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural DUT: one full transfer, returns received number
  task automatic transfer(input logic [15:0] num, input bit ign);
    logic [15:0] got;
    int highCnt;
    got = '0;
    ignoreBusy = ign;
    trigNum = num;
    trigReq = 1'b1;
    @(negedge clk);
    trigReq = 1'b0;
    chk(trigOut == 1'b1, "R2", trigOut, 1);
    if (!ign) begin
      waitN(2);
      dutBusy = 1'b1;
      waitN(2);
      chk(trigOut == 1'b1, "R6", trigOut, 1);
      waitN(1);
      chk(trigOut == 1'b0, "R6", trigOut, 0);
    end else begin
      highCnt = 1;
      @(negedge clk);
      while (trigOut && highCnt < 20) begin
        highCnt++;
        @(negedge clk);
      end
      chk(highCnt == 4, "R7", highCnt, 4);
    end
    waitN(8);
    for (int i = 0; i < 16; i++) begin
      dutClk = 1'b1;
      waitN(3);
      got[i] = trigOut;
      if (i == 5) begin
        trigNum = ~num;   // R9: ignored mid-transfer
        trigReq = 1'b1;
      end
      waitN(9);
      trigReq = 1'b0;
      dutClk = 1'b0;
      waitN(12);
    end
    chk(got == num, "R8", got, num);
    chk(got != ~num || num == ~num, "R9", got, num);
    if (!ign) begin
      chk(ready == 1'b0, "R10", ready, 0);
      chk(trigOut == 1'b0, "R10", trigOut, 0);
      dutBusy = 1'b0;
      waitN(4);
      chk(ready == 1'b1, "R10", ready, 1);
    end else begin
      waitN(4);
      chk(ready == 1'b1, "R10", ready, 1);
    end
    chk(trigOut == 1'b0, "R11", trigOut, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitN(3);
    chk(trigOut == 1'b0, "R1", trigOut, 0);
    rst = 1'b0;
    waitN(3);
    chk(ready == 1'b1, "R1", ready, 1);
    chk(trigOut == 1'b0, "R1", trigOut, 0);

    // R3: masked port
    portEnable = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R3", ready, 0);
    trigReq = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(trigOut == 1'b0, "R3", trigOut, 0);
    end
    trigReq = 1'b0;
    portEnable = 1'b1;
    waitN(2);

    // R4: busy veto and its override
    dutBusy = 1'b1;
    waitN(4);
    chk(ready == 1'b0, "R4", ready, 0);
    trigReq = 1'b1;
    waitN(3);
    chk(trigOut == 1'b0, "R4", trigOut, 0);
    trigReq = 1'b0;
    ignoreBusy = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R4", ready, 1);
    ignoreBusy = 1'b0;
    dutBusy = 1'b0;
    waitN(4);
    chk(ready == 1'b1, "R4", ready, 1);

    // R5: DUT clock veto
    dutClk = 1'b1;
    waitN(4);
    chk(ready == 1'b1, "R5", ready, 1);
    clkVetoEn = 1'b1;
    @(negedge clk);
    chk(ready == 1'b0, "R5", ready, 0);
    dutClk = 1'b0;
    waitN(4);
    chk(ready == 1'b1, "R5", ready, 1);
    clkVetoEn = 1'b0;

    // R8 sweeps: walking ones and zeros, busy handshake
    for (int b = 0; b < 16; b++) transfer(16'(1 << b), 1'b0);
    for (int b = 0; b < 16; b++) transfer(~16'(1 << b), 1'b0);
    transfer(16'h0000, 1'b0);
    transfer(16'hFFFF, 1'b0);
    transfer(16'hA5C3, 1'b0);
    // ignore-busy mode
    for (int b = 0; b < 16; b += 3) transfer(16'(1 << b) ^ 16'h3C0F, 1'b1);
    transfer(16'h0000, 1'b1);
    transfer(16'hFFFF, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule